// File: doc/BRIEF.md
# Priority-Gated External Interrupt Router

This block collects level-sensitive interrupt lines from devices across a chip and presents them to a set of target contexts. Each context has one interrupt output. Every source has a small priority value. Every context has its own enable bit for each source and a priority threshold. A context's output is raised when some source is pending, is enabled for that context, and has a priority strictly above that context's threshold.

Software running on a context takes an interrupt by reading that context's claim word. The read returns the best eligible source ID and takes the source out of circulation. Once the device has been serviced, software writes the same ID back to the claim word. Repeated claim reads drain a context, one source per read, until the read returns 0. All registers are 32-bit words on a simple bus that accepts one access per cycle, at fixed byte offsets. Source ID 0 is reserved and has no storage. The defaults build 31 sources and 2 contexts; NSRC may be set up to 1023 and NCTX up to 15872.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all priorities, enables and thresholds are zero, no source is pending or claimed, every `irq_o` bit is low and a claim read returns 0.
- R2: The priority of source ID n (1..NSRC) is at byte offset 4·n and holds the low PRIO_W bits of the written word; it reads back zero-extended. Offset 0 (ID 0) and IDs above NSRC read 0 and ignore writes.
- R3: The enable bits of context c are at 0x2000 + 0x80·c. Word w, bit b, belongs to source ID 32·w + b. The bit for ID 0 and bits above NSRC read 0.
- R4: A source whose line is high while it is neither pending nor claimed becomes pending one cycle later. Pending bits can be read at 0x1000 + 4·w using the same bit layout as R3. Writes to these words are ignored, and a pending bit stays set after its line drops.
- R5: `irq_o[c]` is high exactly when some pending source that is enabled in context c has a priority strictly greater than that context's threshold (0x200000 + 0x1000·c). It reflects the register state with no further delay.
- R6: A read of the claim word (0x200000 + 0x1000·c + 4) returns the eligible source, in the sense of R5, with the highest priority. On equal priority the lowest ID wins. The read returns 0 when no source is eligible. The claimed source leaves the pending set.
- R7: A claimed source neither becomes pending nor is returned by any claim read until it is completed, even while its line stays high.
- R8: Writing a claimed ID to the claim word of a context that has that ID enabled completes the source. If the line is still high, the source is pending again one cycle after the completion takes effect.
- R9: A completion write whose ID is 0, above NSRC, not currently claimed, or not enabled in the addressed context changes nothing.
- R10: Reads of any address outside the mapped words return 0, and writes to such addresses change no state.
- R11: `bus_rdata_o` carries a read's result from the clock edge that accepts the read. It holds that value until the next read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NSRC | Level interrupt lines; bit n is source ID n (range NSRC:1) |
| bus_req_i | input | 1 | Access request, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | NCTX | Interrupt output, one per context |

## Verification
Some states are hard to reach from the ports. One is a source that is claimed and still asserted, while another context tries to complete it without having it enabled. Another is several sources of equal priority pending together. The directed part of the bench builds both on purpose: it raises several lines with tied priorities, drains one context, and then issues bad completions before the good one. The random part holds lines at random levels over thousands of cycles. About half of its completion writes pick an ID that is actually claimed, aimed at a random context, so completions that are accepted and completions that are refused both occur often.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
    localparam logic [31:0] THR_WORD   = 32'd0;
    localparam logic [31:0] CLAIM_WORD = 32'd1;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

endpackage

// File: rtl/eic_decode.sv
module eic_decode
    import eic_pkg::*;
#(
    parameter int unsigned NSRC   = 31,
    parameter int unsigned NCTX   = 2,
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned ID_W   = $clog2(NSRC + 1),
    parameter int unsigned CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           rg_o,
    output logic [ID_W-1:0]   id_o,
    output logic [4:0]        word_o,
    output logic [CTX_W-1:0]  ctx_o
);
    localparam int unsigned NWORD = (NSRC + 32) / 32;

    logic [31:0] a;
    logic [31:0] slot;

    always_comb begin
        a      = 32'(addr_i);
        slot   = '0;
        rg_o   = RG_NONE;
        id_o   = ID_W'(a[11:2]);
        word_o = a[6:2];
        ctx_o  = '0;
        if (a < PEND_BASE) begin
            if (a[11:2] != 0 && 32'(a[11:2]) <= NSRC) rg_o = RG_PRIO;
        end else if (a < PEND_BASE + EN_STRIDE) begin
            if (32'(a[6:2]) < NWORD) rg_o = RG_PEND;
        end else if (a >= EN_BASE && a < CTX_BASE) begin
            slot = (a - EN_BASE) / EN_STRIDE;
            if (slot < NCTX && 32'(a[6:2]) < NWORD) begin
                rg_o  = RG_EN;
                ctx_o = CTX_W'(slot);
            end
        end else if (a >= CTX_BASE) begin
            slot = (a - CTX_BASE) / CTX_STRIDE;
            if (slot < NCTX) begin
                ctx_o = CTX_W'(slot);
                if (32'(a[11:2]) == THR_WORD)        rg_o = RG_THR;
                else if (32'(a[11:2]) == CLAIM_WORD) rg_o = RG_CLAIM;
            end
        end
    end

endmodule

// File: rtl/eic_gateway.sv
module eic_gateway (
    input  logic lvl_i,
    input  logic pend_i,
    input  logic busy_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o,
    output logic busy_o
);
    // a claimed source is held off until its completion arrives
    always_comb begin
        pend_o = !claim_i && (pend_i || (lvl_i && !busy_i));
        busy_o = claim_i || (busy_i && !done_i);
    end

endmodule

// File: rtl/eic_arbiter.sv
module eic_arbiter #(
    parameter int unsigned NSRC   = 31,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned ID_W   = $clog2(NSRC + 1)
) (
    input  logic [NSRC:0]             cand_i,
    input  logic [NSRC:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thr_i,
    output logic [ID_W-1:0]           id_o
);
    logic [PRIO_W-1:0] best_p;

    // strict compare: the floor starts at the threshold and ties keep the lower ID
    always_comb begin
        best_p = thr_i;
        id_o   = '0;
        for (int i = 1; i <= int'(NSRC); i++) begin
            if (cand_i[ID_W'(i)] && prio_i[ID_W'(i)] > best_p) begin
                best_p = prio_i[ID_W'(i)];
                id_o   = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int unsigned NSRC   = 31,
    parameter int unsigned NCTX   = 2,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned ADDR_W = 26
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC:1]     irq_src_i,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [NCTX-1:0]   irq_o
);
    localparam int unsigned ID_W  = $clog2(NSRC + 1);
    localparam int unsigned CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;

    typedef struct packed {
        logic [NSRC:0][PRIO_W-1:0] prio;
        logic [NCTX-1:0][NSRC:0]   en;
        logic [NCTX-1:0][PRIO_W-1:0] thr;
        logic [NSRC:0]             pend;
        logic [NSRC:0]             busy;
        logic [31:0]               rdata;
    } state_t;

    state_t st_d, st_q;

    region_e                     rg;
    logic [ID_W-1:0]             rg_id;
    logic [4:0]                  rg_word;
    logic [CTX_W-1:0]            rg_ctx;
    logic [NCTX-1:0][ID_W-1:0]   best_id;
    logic [NSRC:1]               claim_hit, done_hit;
    logic [NSRC:1]               gw_pend, gw_busy;
    logic                        rd_en, wr_en;
    logic [ID_W-1:0]             wid;

    // visible copies for the bound checker
    logic [NSRC:0]               pend_vis, busy_vis;
    logic [NCTX-1:0][NSRC:0]     en_vis;
    logic [NCTX-1:0][PRIO_W-1:0] thr_vis;

    function automatic logic [31:0] word_of(input logic [NSRC:0] v, input logic [4:0] w);
        logic [31:0] r;
        r = '0;
        for (int b = 0; b < 32; b++) begin
            if (32'(w) * 32 + 32'(b) <= NSRC) r[b] = v[ID_W'(32'(w) * 32 + 32'(b))];
        end
        return r;
    endfunction

    eic_decode #(
        .NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W), .ID_W(ID_W), .CTX_W(CTX_W)
    ) u_dec (
        .addr_i(bus_addr_i),
        .rg_o  (rg),
        .id_o  (rg_id),
        .word_o(rg_word),
        .ctx_o (rg_ctx)
    );

    for (genvar c = 0; c < int'(NCTX); c++) begin : g_ctx
        eic_arbiter #(
            .NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
        ) u_arb (
            .cand_i(st_q.pend & st_q.en[c]),
            .prio_i(st_q.prio),
            .thr_i (st_q.thr[c]),
            .id_o  (best_id[c])
        );
        assign irq_o[c] = (best_id[c] != '0);
    end

    assign rd_en = bus_req_i && !bus_we_i;
    assign wr_en = bus_req_i && bus_we_i;
    assign wid   = ID_W'(bus_wdata_i);

    // claim and completion strobes, one-hot by source ID
    always_comb begin
        claim_hit = '0;
        done_hit  = '0;
        if (rd_en && rg == RG_CLAIM && best_id[rg_ctx] != '0)
            claim_hit[best_id[rg_ctx]] = 1'b1;
        if (wr_en && rg == RG_CLAIM && bus_wdata_i != 0 && bus_wdata_i <= NSRC) begin
            if (st_q.busy[wid] && st_q.en[rg_ctx][wid]) done_hit[wid] = 1'b1;
        end
    end

    for (genvar s = 1; s <= int'(NSRC); s++) begin : g_src
        eic_gateway u_gw (
            .lvl_i  (irq_src_i[s]),
            .pend_i (st_q.pend[s]),
            .busy_i (st_q.busy[s]),
            .claim_i(claim_hit[s]),
            .done_i (done_hit[s]),
            .pend_o (gw_pend[s]),
            .busy_o (gw_busy[s])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = {gw_pend, 1'b0};
        st_d.busy = {gw_busy, 1'b0};
        if (rd_en) begin
            unique case (rg)
                RG_PRIO:  st_d.rdata = 32'(st_q.prio[rg_id]);
                RG_PEND:  st_d.rdata = word_of(st_q.pend, rg_word);
                RG_EN:    st_d.rdata = word_of(st_q.en[rg_ctx], rg_word);
                RG_THR:   st_d.rdata = 32'(st_q.thr[rg_ctx]);
                RG_CLAIM: st_d.rdata = 32'(best_id[rg_ctx]);
                default:  st_d.rdata = '0;
            endcase
        end
        if (wr_en) begin
            unique case (rg)
                RG_PRIO: st_d.prio[rg_id] = bus_wdata_i[PRIO_W-1:0];
                RG_THR:  st_d.thr[rg_ctx] = bus_wdata_i[PRIO_W-1:0];
                RG_EN: begin
                    for (int b = 0; b < 32; b++) begin
                        if (32'(rg_word) * 32 + 32'(b) >= 1 &&
                            32'(rg_word) * 32 + 32'(b) <= NSRC)
                            st_d.en[rg_ctx][ID_W'(32'(rg_word) * 32 + 32'(b))] = bus_wdata_i[b];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bus_rdata_o = st_q.rdata;
    assign pend_vis    = st_q.pend;
    assign busy_vis    = st_q.busy;
    assign en_vis      = st_q.en;
    assign thr_vis     = st_q.thr;

endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
    parameter int unsigned NSRC   = 31,
    parameter int unsigned NCTX   = 2,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned ADDR_W = 26
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        bus_req_i,
    input logic                        bus_we_i,
    input logic [ADDR_W-1:0]           bus_addr_i,
    input logic [31:0]                 bus_rdata_o,
    input logic [NCTX-1:0]             irq_o,
    input logic [NSRC:0]               pend_q,
    input logic [NSRC:0]               busy_q,
    input logic [NCTX-1:0][NSRC:0]     en_q,
    input logic [NCTX-1:0][PRIO_W-1:0] thr_q
);
    localparam int unsigned ID_W = $clog2(NSRC + 1);

    logic [31:0] a;
    logic        is_claim;
    logic        claim_q;

    assign a        = 32'(bus_addr_i);
    assign is_claim = bus_req_i && !bus_we_i && a >= 32'h0020_0000 &&
                      ((a - 32'h0020_0000) >> 12) < NCTX && 32'(a[11:2]) == 32'd1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) claim_q <= 1'b0;
        else         claim_q <= is_claim;
    end

    for (genvar c = 0; c < int'(NCTX); c++) begin : g_ctx
        AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[c] |-> (|(pend_q & en_q[c]))); // R5
        AST_IRQ_TOP_THRESHOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (thr_q[c] == {PRIO_W{1'b1}}) |-> !irq_o[c]); // R5
    end

    AST_PEND_BUSY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|(pend_q & busy_q))); // R7

    AST_ID0_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_q[0] && !busy_q[0]); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_req_i && !bus_we_i) |=> $stable(bus_rdata_o)); // R11

    AST_CLAIM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        claim_q |-> bus_rdata_o <= NSRC); // R6

    AST_CLAIM_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_q && bus_rdata_o != 0) |->
            (busy_q[ID_W'(bus_rdata_o)] && !pend_q[ID_W'(bus_rdata_o)])); // R6

endmodule

bind ext_irq_ctrl eic_checker #(
    .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_rdata_o(bus_rdata_o),
    .irq_o      (irq_o),
    .pend_q     (pend_vis),
    .busy_q     (busy_vis),
    .en_q       (en_vis),
    .thr_q      (thr_vis)
);

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;
    localparam int NSRC = 31;
    localparam int NCTX = 2;
    localparam int PRIO_W = 3;
    localparam int ADDR_W = 26;
    localparam int NW = (NSRC + 32) / 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC:1]     src = '0;
    logic              req = 1'b0, we = 1'b0;
    logic [31:0]       addr = '0, wdata = '0;
    logic [31:0]       rdata;
    logic [NCTX-1:0]   irq;

    int total = 0;
    int bad = 0;

    logic [PRIO_W-1:0] m_prio [0:NSRC];
    bit                m_en   [0:NCTX-1][0:NSRC];
    logic [PRIO_W-1:0] m_thr  [0:NCTX-1];
    bit                m_pend [0:NSRC];
    bit                m_busy [0:NSRC];
    logic [31:0]       m_rd;

    always #4 clk = ~clk; // 125 MHz

    ext_irq_ctrl #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src),
        .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr[ADDR_W-1:0]),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] a_prio(int id);     return 32'(4 * id); endfunction
    function automatic logic [31:0] a_pend(int w);      return 32'h1000 + 32'(4 * w); endfunction
    function automatic logic [31:0] a_en(int c, int w); return 32'h2000 + 32'('h80 * c + 4 * w); endfunction
    function automatic logic [31:0] a_thr(int c);       return 32'h20_0000 + 32'('h1000 * c); endfunction
    function automatic logic [31:0] a_clm(int c);       return a_thr(c) + 32'd4; endfunction

    function automatic int best(int c);
        int id = 0;
        logic [PRIO_W-1:0] bp = m_thr[c];
        for (int i = 1; i <= NSRC; i++)
            if (m_pend[i] && m_en[c][i] && m_prio[i] > bp) begin bp = m_prio[i]; id = i; end
        return id;
    endfunction

    function automatic logic [31:0] exp_irq();
        logic [31:0] r = '0;
        for (int c = 0; c < NCTX; c++) r[c] = (best(c) != 0);
        return r;
    endfunction

    // kind: 0 none, 1 prio, 2 pending, 3 enable, 4 threshold, 5 claim
    task automatic bdec(input logic [31:0] a, output int kind, output int idx, output int c);
        kind = 0; idx = 0; c = 0;
        if (a < 32'h1000) begin
            if (a / 4 >= 1 && a / 4 <= NSRC) begin kind = 1; idx = int'(a / 4); end
        end else if (a < 32'h1080) begin
            if ((a - 32'h1000) / 4 < NW) begin kind = 2; idx = int'((a - 32'h1000) / 4); end
        end else if (a >= 32'h2000 && a < 32'h20_0000) begin
            c = int'((a - 32'h2000) / 32'h80); idx = int'((a % 32'h80) / 4);
            if (c < NCTX && idx < NW) kind = 3;
        end else if (a >= 32'h20_0000) begin
            c = int'((a - 32'h20_0000) / 32'h1000);
            if (c < NCTX) begin
                if ((a % 32'h1000) / 4 == 0) kind = 4;
                else if ((a % 32'h1000) / 4 == 1) kind = 5;
            end
        end
    endtask

    task automatic step_model(input bit rq, input bit w, input logic [31:0] a, input logic [31:0] wd);
        int kind, idx, c;
        int k = 0;
        int d = 0;
        bdec(a, kind, idx, c);
        if (rq && !w) begin
            m_rd = '0;
            case (kind)
                1: m_rd = 32'(m_prio[idx]);
                2: for (int b = 0; b < 32; b++) if (idx * 32 + b <= NSRC) m_rd[b] = m_pend[idx * 32 + b];
                3: for (int b = 0; b < 32; b++) if (idx * 32 + b <= NSRC) m_rd[b] = m_en[c][idx * 32 + b];
                4: m_rd = 32'(m_thr[c]);
                5: begin k = best(c); m_rd = 32'(k); end
                default: ;
            endcase
        end
        if (rq && w && kind == 5 && wd >= 1 && wd <= NSRC)
            if (m_busy[wd] && m_en[c][wd]) d = int'(wd);
        for (int i = 1; i <= NSRC; i++) begin
            if (i == k) begin m_pend[i] = 0; m_busy[i] = 1; end
            else begin
                if (src[i] && !m_busy[i]) m_pend[i] = 1;
                if (i == d) m_busy[i] = 0;
            end
        end
        if (rq && w) begin
            case (kind)
                1: m_prio[idx] = wd[PRIO_W-1:0];
                3: for (int b = 0; b < 32; b++)
                       if (idx * 32 + b >= 1 && idx * 32 + b <= NSRC) m_en[c][idx * 32 + b] = wd[b];
                4: m_thr[c] = wd[PRIO_W-1:0];
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle; called just after a falling edge
    task automatic op(input string tag, input bit rq, input bit w, input logic [31:0] a, input logic [31:0] wd);
        req = rq; we = w; addr = a; wdata = wd;
        @(posedge clk);
        step_model(rq, w, a, wd);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        chk("R5 irq_o", 32'(irq), exp_irq());
        if (rq && !w) chk(tag, rdata, m_rd);
        else          chk("R11 rdata hold", rdata, m_rd);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) op("R11", 1'b0, 1'b0, 32'h0, 32'h0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1..: actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i <= NSRC; i++) begin m_prio[i] = '0; m_pend[i] = 0; m_busy[i] = 0; end
        for (int c = 0; c < NCTX; c++) begin
            m_thr[c] = '0;
            for (int i = 0; i <= NSRC; i++) m_en[c][i] = 0;
        end
        m_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 rdata after reset", rdata, 32'h0);
        op("R1 claim ctx0", 1, 0, a_clm(0), 0);
        op("R1 claim ctx1", 1, 0, a_clm(1), 0);
        op("R1 prio", 1, 0, a_prio(5), 0);
        op("R1 enable", 1, 0, a_en(1, 0), 0);

        // R2 priority words
        op("R2", 1, 1, a_prio(3), 32'd7);
        op("R2 readback", 1, 0, a_prio(3), 0);
        op("R2", 1, 1, a_prio(0), 32'd5);
        op("R2 id0 reads zero", 1, 0, a_prio(0), 0);
        op("R2", 1, 1, a_prio(6), 32'hFFFF_FFFA);
        op("R2 low bits only", 1, 0, a_prio(6), 0);
        op("R2", 1, 1, a_prio(NSRC + 1), 32'd3);
        op("R2 id above range", 1, 0, a_prio(NSRC + 1), 0);

        // R3 enable layout
        op("R3", 1, 1, a_en(1, 0), 32'hFFFF_FFFF);
        op("R3 id0 bit zero", 1, 0, a_en(1, 0), 0);
        op("R3 ctx0 untouched", 1, 0, a_en(0, 0), 0);
        op("R3", 1, 1, a_en(1, 0), 32'h0);

        // R4 pending capture, read-only, sticky
        src[3] = 1'b1;
        idle(1);
        op("R4 pending bit3", 1, 0, a_pend(0), 0);
        src[3] = 1'b0;
        op("R4", 1, 1, a_pend(0), 32'h0);
        op("R4 pending sticky and read-only", 1, 0, a_pend(0), 0);

        // R5 strict threshold
        op("R5", 1, 1, a_prio(3), 32'd2);
        op("R5", 1, 1, a_en(0, 0), 32'h0000_0218);
        op("R5", 1, 1, a_thr(0), 32'd2);
        chk("R5 equal to threshold stays low", 32'(irq[0]), 32'h0);
        op("R5", 1, 1, a_thr(0), 32'd1);
        chk("R5 above threshold raises", 32'(irq[0]), 32'h1);
        op("R5", 1, 1, a_thr(0), 32'd0);

        // R6 ordering: ties by lowest ID, then lower priority, then none
        op("R6", 1, 1, a_prio(4), 32'd5);
        op("R6", 1, 1, a_prio(9), 32'd5);
        src[4] = 1'b1; src[9] = 1'b1; src[3] = 1'b1;
        idle(2);
        op("R6 tie lowest id", 1, 0, a_clm(0), 0);
        chk("R6 expect 4", rdata, 32'd4);
        op("R6 next tie", 1, 0, a_clm(0), 0);
        chk("R6 expect 9", rdata, 32'd9);
        op("R6 lower prio", 1, 0, a_clm(0), 0);
        chk("R6 expect 3", rdata, 32'd3);
        op("R6 drained", 1, 0, a_clm(0), 0);
        chk("R6 expect 0", rdata, 32'd0);

        // R7 claimed sources stay out while lines are high
        idle(3);
        op("R7 no pending while claimed", 1, 0, a_pend(0), 0);
        chk("R7 pend word zero", rdata, 32'h0);
        op("R7 claim empty", 1, 0, a_clm(0), 0);

        // R9 bad completions
        op("R9", 1, 1, a_clm(0), 32'd5);
        op("R9", 1, 1, a_clm(1), 32'd4);
        op("R9", 1, 1, a_clm(0), 32'd0);
        op("R9", 1, 1, a_clm(0), 32'(NSRC + 1));
        idle(2);
        op("R9 source 4 still claimed", 1, 0, a_pend(0), 0);
        chk("R9 pend word zero", rdata, 32'h0);

        // R8 good completion re-arms
        op("R8", 1, 1, a_clm(0), 32'd4);
        idle(1);
        op("R8 pending again", 1, 0, a_pend(0), 0);
        chk("R8 bit4 set", rdata, 32'h0000_0010);
        op("R8 reclaim", 1, 0, a_clm(0), 0);
        chk("R8 expect 4", rdata, 32'd4);

        // R10 unmapped space
        op("R10", 1, 1, 32'h0010_0000, 32'hFFFF_FFFF);
        op("R10", 1, 1, a_en(NCTX, 0), 32'hFFFF_FFFF);
        op("R10", 1, 1, a_thr(0) + 32'h8, 32'd7);
        op("R10", 1, 1, a_thr(NCTX), 32'd7);
        op("R10 read hole", 1, 0, 32'h0010_0000, 0);
        op("R10 read ctx beyond", 1, 0, a_en(NCTX, 0), 0);
        op("R10 read ctrl gap", 1, 0, a_thr(0) + 32'h8, 0);
        op("R10 read 0x1100", 1, 0, 32'h0000_1100, 0);
        op("R10 read top", 1, 0, 32'h03FF_FFFC, 0);
        op("R10 thr0 unchanged", 1, 0, a_thr(0), 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int sel = int'($urandom_range(99));
            int c = int'($urandom_range(NCTX - 1));
            if ($urandom_range(7) == 0) src[$urandom_range(NSRC, 1)] ^= 1'b1;
            if (sel < 30) op("R6 random claim", 1, 0, a_clm(c), 0);
            else if (sel < 55) begin
                int id = int'($urandom_range(NSRC + 2));
                if ($urandom_range(1) == 1) begin
                    int st = int'($urandom_range(NSRC, 1));
                    for (int j = 0; j < NSRC; j++)
                        if (m_busy[(st + j - 1) % NSRC + 1]) begin id = (st + j - 1) % NSRC + 1; break; end
                end
                op("R8 random complete", 1, 1, a_clm(c), 32'(id));
            end
            else if (sel < 65) op("R2 random prio", 1, 1, a_prio(int'($urandom_range(NSRC + 1))), $urandom);
            else if (sel < 73) op("R3 random enable", 1, 1, a_en(c, 0), $urandom);
            else if (sel < 80) op("R5 random thr", 1, 1, a_thr(c), 32'($urandom_range(2 ** PRIO_W - 1)));
            else if (sel < 85) op("R4 random pend", 1, 0, a_pend(0), 0);
            else if (sel < 90) op("R3 random en read", 1, 0, a_en(c, 0), 0);
            else if (sel < 94) op("R10 random hole", 1, 0, 32'h0000_1000 + 32'($urandom_range(255)) * 4 + 32'h80, 0);
            else op("R11 random idle", 0, 0, 0, 0);
        end

        summary();
    end
endmodule